// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer built from an 8-bit up-counter and a control/status byte. The counter steps on ticks from a programmable prescaler. When it wraps from all ones to zero, the block sets a sticky overflow flag and sends a one-clock pulse on either a reset output or an interrupt output. Software picks which output is used.

Software reaches both registers through a small register bus: a one-bit address, a write strobe and a 16-bit write word. The upper byte of a write is a guard key, and each register has its own key. The write takes effect only when the key matches. The lower byte is the new register value. Reads return the addressed 8-bit value with no key needed. A runaway program that writes stray data therefore cannot easily reload the counter or stop the watchdog.

Top module: `keyed_wdt`

## Requirements
- R1: A write with `addr`=0 loads the counter from `wr_data[7:0]` only when `wr_data[15:8]` is 0x5A. The new value is readable in the cycle after the write edge.
- R2: A write with `addr`=1 loads the control/status byte from `wr_data[7:0]` only when `wr_data[15:8]` is 0xA5. Bit 5 follows the rule of R9.
- R3: A write whose upper byte is not the key of the addressed register is ignored. Both registers keep their values.
- R4: `rd_data` shows the counter when `addr`=0 and the control/status byte when `addr`=1, combinationally and without any key.
- R5: After reset the counter and the control/status byte are 0x00, so counting is off and the division select is 0 (divide by 32). Both pulse outputs are low.
- R6: Control/status bits [2:0] hold a select S from 0 to 7. While counting is enabled, the counter advances once every 2^(S+5) clock cycles, so the step period runs from 32 to 4096 cycles.
- R7: Control/status bit 7 enables counting. While it is 0, the counter holds its value and the prescaler is held at zero. Enabling starts a full period, so the first step comes 2^(S+5) cycles after the enabling write edge.
- R8: A step from 0xFF to 0x00 sets control/status bit 5. It also raises `rst_pulse` if bit 6 is 1, or `irq_pulse` if bit 6 is 0, for exactly one cycle: the first cycle in which the counter reads 0x00.
- R9: Bit 5 is sticky. A keyed control/status write clears it when bit 5 of the data is 0. A write with bit 5 at 1 leaves the flag unchanged and never sets it. If a wrap and a clearing write fall in the same cycle, the flag is set.
- R10: A keyed counter write restarts the prescaler. The next step comes exactly 2^(S+5) cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 1 | Register select: 0 counter, 1 control/status |
| wr_data | input | 16 | Key in [15:8], new value in [7:0] |
| rd_data | output | 8 | Value of the addressed register |
| rst_pulse | output | 1 | One-cycle pulse on wrap when bit 6 is 1 |
| irq_pulse | output | 1 | One-cycle pulse on wrap when bit 6 is 0 |

## Verification
A register load is due in the cycle after the write edge. A read is due in the same cycle, because `rd_data` is combinational. After an enabling or counter write at edge E, the counter reaches 0x00 and the pulse is high in the cycle after edge E + (256 - start)·2^(S+5). The pulse is gone one edge later. The bench computes that edge count from the requirements and samples on falling edges: one cycle before the due cycle (no pulse, counter at 0xFF), in the due cycle, and one cycle after it. Because the checks bracket the event this closely, a prescaler that is off by one cycle or a pulse that lasts two cycles is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W    = 8;
    localparam int EN_BIT   = 7;
    localparam int MODE_BIT = 6;
    localparam int OVF_BIT  = 5;

    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] csr;
        logic             rst;
        logic             irq;
    } wdt_regs_t;
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
    parameter int          W   = 8,
    parameter logic [W-1:0] KEY = '0
) (
    input  logic           wr_en,
    input  logic           hit,
    input  logic [2*W-1:0] data,
    output logic           load,
    output logic [W-1:0]   value
);
    assign value = data[W-1:0];
    assign load  = wr_en && hit && (data[2*W-1:W] == KEY);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W    = 3,
    parameter int BASE_LOG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int PRE_W = BASE_LOG + NSEL - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [NSEL-1:0]  wrap_vec;

    // each select value watches its own low slice of the divider
    for (genvar s = 0; s < NSEL; s++) begin : g_tap
        assign wrap_vec[s] = &pre_q[s+BASE_LOG-1:0];
    end

    always_comb begin
        if (!run || restart) pre_d = '0;
        else                 pre_d = pre_q + 1'b1;
        tick = run && wrap_vec[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int   SEL_W    = 3,
    parameter int   BASE_LOG = 5,
    parameter logic [7:0] KEY_CNT = 8'h5A,
    parameter logic [7:0] KEY_CSR = 8'hA5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        addr,
    input  logic [15:0] wr_data,
    output logic [7:0]  rd_data,
    output logic        rst_pulse,
    output logic        irq_pulse
);
    import wdt_pkg::*;

    localparam logic [REG_W-1:0] CNT_MAX = '1;

    wdt_regs_t r_d, r_q;
    logic             cnt_ld, csr_ld, tick, wrap;
    logic [REG_W-1:0] cnt_val, csr_val;
    logic [REG_W-1:0] cnt_q, csr_q;

    assign cnt_q = r_q.cnt;
    assign csr_q = r_q.csr;

    wdt_key_gate #(.W(REG_W), .KEY(KEY_CNT)) u_gate_cnt (
        .wr_en (wr_en),
        .hit   (!addr),
        .data  (wr_data),
        .load  (cnt_ld),
        .value (cnt_val)
    );

    wdt_key_gate #(.W(REG_W), .KEY(KEY_CSR)) u_gate_csr (
        .wr_en (wr_en),
        .hit   (addr),
        .data  (wr_data),
        .load  (csr_ld),
        .value (csr_val)
    );

    wdt_prescaler #(.SEL_W(SEL_W), .BASE_LOG(BASE_LOG)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.csr[EN_BIT]),
        .restart (cnt_ld),
        .sel     (r_q.csr[SEL_W-1:0]),
        .tick    (tick)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rst = 1'b0;
        r_d.irq = 1'b0;
        wrap    = tick && (r_q.cnt == CNT_MAX) && !cnt_ld;

        if (cnt_ld)    r_d.cnt = cnt_val;
        else if (tick) r_d.cnt = r_q.cnt + 1'b1;

        if (csr_ld) begin
            r_d.csr          = csr_val;
            r_d.csr[OVF_BIT] = csr_val[OVF_BIT] & r_q.csr[OVF_BIT];
        end

        // overflow wins over a same-cycle clearing write
        if (wrap) begin
            r_d.csr[OVF_BIT] = 1'b1;
            if (r_q.csr[MODE_BIT]) r_d.rst = 1'b1;
            else                   r_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data   = addr ? r_q.csr : r_q.cnt;
    assign rst_pulse = r_q.rst;
    assign irq_pulse = r_q.irq;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter logic [7:0] KEY_CNT = 8'h5A,
    parameter logic [7:0] KEY_CSR = 8'hA5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        addr,
    input logic [15:0] wr_data,
    input logic [7:0]  cnt,
    input logic [7:0]  csr,
    input logic        rst_pulse,
    input logic        irq_pulse
);
    logic cnt_key_ok, csr_key_bad, pulse;
    assign cnt_key_ok  = wr_en && !addr && (wr_data[15:8] == KEY_CNT);
    assign csr_key_bad = wr_en && addr && (wr_data[15:8] != KEY_CSR);
    assign pulse       = rst_pulse || irq_pulse;

    a_r1_keyed_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_key_ok |=> cnt == $past(wr_data[7:0]));

    a_r3_bad_key_csr: assert property (@(posedge clk) disable iff (!rst_n)
        csr_key_bad |=> (csr[7:6] == $past(csr[7:6])) && (csr[4:0] == $past(csr[4:0])));

    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr[7] && !cnt_key_ok) |=> $stable(cnt));

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_pulse && irq_pulse));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> csr[5]);

    a_r8_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> cnt == 8'h00);
endmodule

bind keyed_wdt wdt_checker #(.KEY_CNT(KEY_CNT), .KEY_CSR(KEY_CSR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .cnt       (cnt_q),
    .csr       (csr_q),
    .rst_pulse (rst_pulse),
    .irq_pulse (irq_pulse)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {sel[2:0], mode, start[7:0]}
    localparam logic [11:0] VECS [NVEC] = '{
        {3'd0, 1'b1, 8'hFF}, {3'd0, 1'b0, 8'hFE}, {3'd1, 1'b0, 8'hFF},
        {3'd2, 1'b1, 8'hFD}, {3'd3, 1'b0, 8'hFF}, {3'd4, 1'b1, 8'hFE},
        {3'd5, 1'b0, 8'hFF}, {3'd6, 1'b1, 8'hFF}, {3'd7, 1'b0, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_data;
    logic        rst_pulse, irq_pulse;
    int          checks = 0;
    int          fails = 0;

    keyed_wdt i_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .rst_pulse(rst_pulse), .irq_pulse(irq_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the write edge
    task automatic wr(input logic a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL timeout: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        rd(1'b0, v); check("R5 counter", v, 8'h00);
        rd(1'b1, v); check("R5 csr", v, 8'h00);
        check("R5 pulses", {rst_pulse, irq_pulse}, 0);

        // R1 / R2 / R4 keyed loads and unkeyed reads
        wr(1'b0, 16'h5A37);
        rd(1'b0, v); check("R1 counter load", v, 8'h37);
        wr(1'b1, 16'hA51B);
        rd(1'b1, v); check("R2 csr load", v, 8'h1B);
        rd(1'b0, v); check("R4 read counter", v, 8'h37);

        // R3 wrong keys ignored
        wr(1'b0, 16'hA599);
        rd(1'b0, v); check("R3 counter bad key", v, 8'h37);
        wr(1'b1, 16'h5A80);
        rd(1'b1, v); check("R3 csr bad key", v, 8'h1B);
        wr(1'b0, 16'h0011);
        rd(1'b0, v); check("R3 counter zero key", v, 8'h37);

        // R7 disabled: sel=3 would step every 256 cycles
        repeat (600) @(negedge clk);
        rd(1'b0, v); check("R7 hold while off", v, 8'h37);

        // R6 / R8 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] sel;
            logic       mode;
            logic [7:0] start;
            int         n;
            {sel, mode, start} = VECS[i];
            n = (256 - int'(start)) << (sel + 5);
            wr(1'b1, 16'hA500);
            wr(1'b0, {8'h5A, start});
            wr(1'b1, {8'hA5, 1'b1, mode, 3'b000, sel});
            repeat (n - 1) @(negedge clk);
            rd(1'b0, v); check("R6 count before wrap", v, 8'hFF);
            check("R8 no pulse early", {rst_pulse, irq_pulse}, 0);
            @(negedge clk);
            rd(1'b0, v); check("R8 counter wrapped", v, 8'h00);
            check("R8 selected pulse", {rst_pulse, irq_pulse},
                  mode ? 2 : 1);
            rd(1'b1, v); check("R8 flag set", v[5], 1);
            @(negedge clk);
            check("R8 pulse one cycle", {rst_pulse, irq_pulse}, 0);
        end

        // R9 sticky flag
        wr(1'b1, 16'hA520);
        rd(1'b1, v); check("R9 write one keeps", v, 8'h20);
        repeat (50) @(negedge clk);
        rd(1'b1, v); check("R9 sticky", v, 8'h20);
        wr(1'b1, 16'hA500);
        rd(1'b1, v); check("R9 write zero clears", v, 8'h00);
        wr(1'b1, 16'hA520);
        rd(1'b1, v); check("R9 write one no set", v, 8'h00);

        // R10 counter write restarts prescaler (sel=0, period 32)
        wr(1'b1, 16'hA580);
        repeat (20) @(negedge clk);
        wr(1'b0, 16'h5A10);
        repeat (30) @(negedge clk);
        rd(1'b0, v); check("R10 no early step", v, 8'h10);
        @(negedge clk);
        rd(1'b0, v); check("R10 no step at 31", v, 8'h10);
        @(negedge clk);
        rd(1'b0, v); check("R10 step at 32", v, 8'h11);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule